// File: doc/BRIEF.md
# Branch Target Buffer Predictor

This block gives a pipeline's fetch stage its guess at the next PC. Each cycle the stage presents its fetch PC, and the block looks it up in a small direct-mapped table. The table is indexed by the low PC bits and checked against a tag made of the remaining bits. On a hit the stored target is the predicted next PC. On a miss the prediction is the sequential address. PCs are word addresses, so the sequential address is PC+1, wrapping modulo 2^PC_W.

A second port carries resolved branches back from the execute side. It holds the branch PC, the resolved target, the taken flag, and the next PC that was predicted for that branch when it was fetched. The block compares the resolved next PC with that earlier guess and raises a mispredict flag for the pipeline controller.

A policy parameter chooses how entries are allocated:
- **Not-taken:** there is no table at all.
- **Backward:** only taken branches that jump to a lower address are stored.
- **Last-outcome:** every taken branch writes its entry, and a not-taken branch removes its own entry.

Top module: `btb_predictor`

## Requirements
- R1: After reset every entry is invalid, so every fetch PC misses until an update is written.
- R2: On a miss `pred_hit` is 0 and `pred_next_pc` equals `fetch_pc`+1 modulo 2^PC_W.
- R3: On a hit `pred_hit` is 1 and `pred_next_pc` is the target stored for that PC, in the same cycle the PC is presented.
- R4: With POLICY = POL_NOT_TAKEN, no update ever produces a hit.
- R5: With POLICY = POL_BACKWARD, an entry is written only when a valid resolved branch is taken and its target is strictly below its PC. Forward branches, self-targets and not-taken branches leave the table unchanged.
- R6: With POLICY = POL_LAST, every valid taken branch writes its entry with the new target, replacing any older target.
- R7: With POLICY = POL_LAST, a valid not-taken branch invalidates the entry at its index only if that entry's tag matches. An entry holding a different tag is kept.
- R8: The index is PC bits [IDX_W-1:0] and the tag is the remaining upper bits. A write to an index replaces whatever branch was held there.
- R9: A lookup in the same cycle as an update of the same entry returns the contents from before the update.
- R10: `mispredict` is 1 in the same cycle exactly when `res_valid` is 1 and the resolved next PC differs from `res_pred_next`. The resolved next PC is `res_target` when `res_taken` is 1, otherwise `res_pc`+1.
- R11: When `res_valid` is 0, the table is not changed, whatever the other update inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | PC_W | PC being fetched this cycle |
| pred_next_pc | output | PC_W | Predicted next fetch PC |
| pred_hit | output | 1 | Fetch PC found in the table |
| res_valid | input | 1 | A resolved branch is presented |
| res_pc | input | PC_W | PC of the resolved branch |
| res_target | input | PC_W | Resolved branch target |
| res_taken | input | 1 | Resolved branch was taken |
| res_pred_next | input | PC_W | Next PC predicted when that branch was fetched |
| mispredict | output | 1 | Resolved next PC differs from the prediction |

## Verification
The bench builds three copies of the block, one per policy, with an 8-bit PC and a 2-bit index (four entries, 6-bit tags). With so small a table, every one of the 256 PCs can be looked up after each update. Index collisions, tag mismatches and PC wrap at 255 therefore come up constantly, and each copy is compared with an arithmetic model of its own allocation rule. Each update cycle also looks up the branch being written, which exercises the read-before-write ordering.

// File: rtl/btb_pkg.sv
package btb_pkg;

    typedef enum logic [1:0] {
        POL_NOT_TAKEN = 2'd0,
        POL_BACKWARD  = 2'd1,
        POL_LAST      = 2'd2
    } policy_e;

    localparam int unsigned DEF_PC_W  = 16;
    localparam int unsigned DEF_IDX_W = 4;

    typedef struct packed {
        logic set;
        logic clr;
    } wr_cmd_t;

endpackage

// File: rtl/btb_table.sv
module btb_table #(
    parameter int unsigned PC_W  = btb_pkg::DEF_PC_W,
    parameter int unsigned IDX_W = btb_pkg::DEF_IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PC_W-1:0]  rd_pc,
    output logic             rd_hit,
    output logic [PC_W-1:0]  rd_target,
    input  btb_pkg::wr_cmd_t wr_cmd,
    input  logic [PC_W-1:0]  wr_pc,
    input  logic [PC_W-1:0]  wr_target
);
    localparam int unsigned N     = 1 << IDX_W;
    localparam int unsigned TAG_W = PC_W - IDX_W;

    logic [N-1:0]     vld;
    logic [TAG_W-1:0] tagq [N];
    logic [PC_W-1:0]  tgtq [N];

    logic [IDX_W-1:0] rd_idx, wr_idx;
    logic [TAG_W-1:0] rd_tag, wr_tag;

    assign rd_idx = rd_pc[IDX_W-1:0];
    assign rd_tag = rd_pc[PC_W-1:IDX_W];
    assign wr_idx = wr_pc[IDX_W-1:0];
    assign wr_tag = wr_pc[PC_W-1:IDX_W];

    for (genvar i = 0; i < N; i++) begin : g_entry
        logic             v_q;
        logic [TAG_W-1:0] t_q;
        logic [PC_W-1:0]  d_q;
        logic             sel;

        assign sel = (wr_idx == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                v_q <= 1'b0;
                t_q <= '0;
                d_q <= '0;
            end else if (sel && wr_cmd.set) begin
                v_q <= 1'b1;
                t_q <= wr_tag;
                d_q <= wr_target;
            end else if (sel && wr_cmd.clr && v_q && (t_q == wr_tag)) begin
                v_q <= 1'b0;
            end
        end

        assign vld[i]  = v_q;
        assign tagq[i] = t_q;
        assign tgtq[i] = d_q;
    end

    // Combinational read of registered state: same-cycle writes are not yet visible.
    assign rd_hit    = vld[rd_idx] && (tagq[rd_idx] == rd_tag);
    assign rd_target = tgtq[rd_idx];

endmodule

// File: rtl/btb_alloc.sv
module btb_alloc #(
    parameter int unsigned      PC_W   = btb_pkg::DEF_PC_W,
    parameter btb_pkg::policy_e POLICY = btb_pkg::POL_LAST
) (
    input  logic             res_valid,
    input  logic [PC_W-1:0]  res_pc,
    input  logic [PC_W-1:0]  res_target,
    input  logic             res_taken,
    output btb_pkg::wr_cmd_t wr_cmd
);
    always_comb begin
        wr_cmd = '0;
        if (res_valid) begin
            unique case (POLICY)
                btb_pkg::POL_BACKWARD: begin
                    wr_cmd.set = res_taken && (res_target < res_pc);
                end
                btb_pkg::POL_LAST: begin
                    wr_cmd.set = res_taken;
                    wr_cmd.clr = !res_taken;
                end
                default: wr_cmd = '0;
            endcase
        end
    end
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor #(
    parameter int unsigned      PC_W   = btb_pkg::DEF_PC_W,
    parameter int unsigned      IDX_W  = btb_pkg::DEF_IDX_W,
    parameter btb_pkg::policy_e POLICY = btb_pkg::POL_LAST
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] fetch_pc,
    output logic [PC_W-1:0] pred_next_pc,
    output logic            pred_hit,
    input  logic            res_valid,
    input  logic [PC_W-1:0] res_pc,
    input  logic [PC_W-1:0] res_target,
    input  logic            res_taken,
    input  logic [PC_W-1:0] res_pred_next,
    output logic            mispredict
);
    logic [PC_W-1:0] seq_pc;
    logic [PC_W-1:0] resolved_next;

    assign seq_pc = fetch_pc + PC_W'(1);

    if (POLICY == btb_pkg::POL_NOT_TAKEN) begin : g_no_table
        assign pred_hit     = 1'b0;
        assign pred_next_pc = seq_pc;
    end else begin : g_table
        btb_pkg::wr_cmd_t wr_cmd;
        logic             hit;
        logic [PC_W-1:0]  tgt;

        btb_alloc #(.PC_W(PC_W), .POLICY(POLICY)) u_alloc (
            .res_valid  (res_valid),
            .res_pc     (res_pc),
            .res_target (res_target),
            .res_taken  (res_taken),
            .wr_cmd     (wr_cmd)
        );

        btb_table #(.PC_W(PC_W), .IDX_W(IDX_W)) u_table (
            .clk       (clk),
            .rst       (rst),
            .rd_pc     (fetch_pc),
            .rd_hit    (hit),
            .rd_target (tgt),
            .wr_cmd    (wr_cmd),
            .wr_pc     (res_pc),
            .wr_target (res_target)
        );

        assign pred_hit     = hit;
        assign pred_next_pc = hit ? tgt : seq_pc;
    end

    assign resolved_next = res_taken ? res_target : (res_pc + PC_W'(1));
    assign mispredict    = res_valid && (resolved_next != res_pred_next);

endmodule

// File: rtl/btb_predictor_chk.sv
module btb_predictor_chk #(
    parameter int unsigned      PC_W   = btb_pkg::DEF_PC_W,
    parameter int unsigned      IDX_W  = btb_pkg::DEF_IDX_W,
    parameter btb_pkg::policy_e POLICY = btb_pkg::POL_LAST
) (
    input logic            clk,
    input logic            rst,
    input logic [PC_W-1:0] fetch_pc,
    input logic [PC_W-1:0] pred_next_pc,
    input logic            pred_hit,
    input logic            res_valid,
    input logic            mispredict
);
    localparam logic IS_NT  = (POLICY == btb_pkg::POL_NOT_TAKEN);
    localparam logic IS_BWD = (POLICY == btb_pkg::POL_BACKWARD);

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !pred_hit); // R1

    AST_MISS_SEQUENTIAL: assert property (@(posedge clk) disable iff (rst)
        !pred_hit |-> (pred_next_pc == fetch_pc + PC_W'(1))); // R2

    AST_NT_NEVER_HITS: assert property (@(posedge clk) disable iff (rst)
        IS_NT |-> !pred_hit); // R4

    AST_BWD_TARGET_BELOW: assert property (@(posedge clk) disable iff (rst)
        (IS_BWD && pred_hit) |-> (pred_next_pc < fetch_pc)); // R5

    AST_NO_MISPRED_IDLE: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> !mispredict); // R10

    AST_IDLE_KEEPS_TABLE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(res_valid) && $stable(fetch_pc))
            |-> ($stable(pred_hit) && $stable(pred_next_pc))); // R11

endmodule

bind btb_predictor btb_predictor_chk #(.PC_W(PC_W), .IDX_W(IDX_W), .POLICY(POLICY)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .fetch_pc     (fetch_pc),
    .pred_next_pc (pred_next_pc),
    .pred_hit     (pred_hit),
    .res_valid    (res_valid),
    .mispredict   (mispredict)
);

// File: tb/btb_predictor_bench.sv
module btb_predictor_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PW = 8;
    localparam int IW = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [PW-1:0] fetch_pc = '0;
    logic          res_valid = 1'b0;
    logic [PW-1:0] res_pc = '0, res_target = '0, res_pred_next = '0;
    logic          res_taken = 1'b0;

    logic [PW-1:0] nx [3];
    logic          h  [3];
    logic          mp [3];

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 0;

    // Reference table for each policy: 0 not-taken, 1 backward, 2 last-outcome.
    logic          mv   [3][4];
    logic [5:0]    mtag [3][4];
    logic [PW-1:0] mtgt [3][4];

    always #(CLK_PERIOD/2) clk = ~clk;

    btb_predictor #(.PC_W(PW), .IDX_W(IW), .POLICY(btb_pkg::POL_NOT_TAKEN)) u_btb_predictor_nt (
        .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .pred_next_pc(nx[0]), .pred_hit(h[0]),
        .res_valid(res_valid), .res_pc(res_pc), .res_target(res_target), .res_taken(res_taken),
        .res_pred_next(res_pred_next), .mispredict(mp[0]));

    btb_predictor #(.PC_W(PW), .IDX_W(IW), .POLICY(btb_pkg::POL_BACKWARD)) u_btb_predictor_bk (
        .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .pred_next_pc(nx[1]), .pred_hit(h[1]),
        .res_valid(res_valid), .res_pc(res_pc), .res_target(res_target), .res_taken(res_taken),
        .res_pred_next(res_pred_next), .mispredict(mp[1]));

    btb_predictor #(.PC_W(PW), .IDX_W(IW), .POLICY(btb_pkg::POL_LAST)) u_btb_predictor (
        .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .pred_next_pc(nx[2]), .pred_hit(h[2]),
        .res_valid(res_valid), .res_pc(res_pc), .res_target(res_target), .res_taken(res_taken),
        .res_pred_next(res_pred_next), .mispredict(mp[2]));

    function automatic logic m_hit(int p, logic [PW-1:0] pc);
        return mv[p][pc[1:0]] && (mtag[p][pc[1:0]] == pc[7:2]);
    endfunction

    function automatic logic [PW-1:0] m_next(int p, logic [PW-1:0] pc);
        return m_hit(p, pc) ? mtgt[p][pc[1:0]] : PW'(pc + 1);
    endfunction

    task automatic m_clear();
        for (int p = 0; p < 3; p++)
            for (int i = 0; i < 4; i++) begin
                mv[p][i] = 1'b0; mtag[p][i] = '0; mtgt[p][i] = '0;
            end
    endtask

    task automatic m_update(logic [PW-1:0] pc, logic [PW-1:0] tg, logic tk);
        // R5: backward only, target strictly below PC
        if (tk && (tg < pc)) begin
            mv[1][pc[1:0]] = 1'b1; mtag[1][pc[1:0]] = pc[7:2]; mtgt[1][pc[1:0]] = tg;
        end
        // R6 / R7: last-outcome
        if (tk) begin
            mv[2][pc[1:0]] = 1'b1; mtag[2][pc[1:0]] = pc[7:2]; mtgt[2][pc[1:0]] = tg;
        end else if (m_hit(2, pc)) begin
            mv[2][pc[1:0]] = 1'b0;
        end
    endtask

    task automatic check(string req, int p, logic [PW-1:0] act, logic [PW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s policy=%0d fetch_pc=%0d actual=%0h expected=%0h", req, p, fetch_pc, act, exp);
        end
    endtask

    task automatic step(logic [PW-1:0] fpc, logic rv, logic [PW-1:0] rpc, logic [PW-1:0] rtg,
                        logic rtk, logic [PW-1:0] rpn, string tag);
        @(negedge clk);
        fetch_pc = fpc; res_valid = rv; res_pc = rpc; res_target = rtg;
        res_taken = rtk; res_pred_next = rpn;
        #1;
        for (int p = 0; p < 3; p++) begin
            string t;
            logic  eh;
            logic  emp;
            eh = m_hit(p, fpc);
            if (tag != "") t = tag;
            else if (p == 0) t = "R4";
            else if (!eh) t = "R2";
            else if (p == 1) t = "R5";
            else t = "R3";
            check(t, p, PW'(h[p]), PW'(eh));
            check(t, p, nx[p], m_next(p, fpc));
            emp = rv && ((rtk ? rtg : PW'(rpc + 1)) != rpn);
            check("R10", p, PW'(mp[p]), PW'(emp));
        end
        if (rv) m_update(rpc, rtg, rtk);
    endtask

    task automatic sweep(string tag);
        for (int pc = 0; pc < 256; pc++) step(PW'(pc), 1'b0, 8'h20, 8'h01, 1'b1, 8'h00, tag);
    endtask

    initial begin
        m_clear();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: empty after reset, every PC misses, including the wrap at 255
        sweep("R1");

        // R3 / R6: backward taken branch stored in policies 1 and 2
        step(8'h45, 1'b1, 8'h45, 8'h12, 1'b1, 8'h46, "R9");
        step(8'h45, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00, "R3");
        // R5: forward taken branch stored only in last-outcome
        step(8'h20, 1'b1, 8'h20, 8'h80, 1'b1, 8'h21, "R9");
        step(8'h20, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00, "R5");
        // R5: self-target not stored in backward mode
        step(8'h33, 1'b1, 8'h33, 8'h33, 1'b1, 8'h34, "R9");
        step(8'h33, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00, "R5");
        // R8: same index, different tag, replaces
        step(8'h61, 1'b1, 8'h61, 8'h33, 1'b1, 8'h62, "R9");
        step(8'h45, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00, "R8");
        step(8'h61, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00, "R8");
        // R6: retarget an existing entry
        step(8'h61, 1'b1, 8'h61, 8'h07, 1'b1, 8'h33, "R9");
        step(8'h61, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00, "R6");
        // R7: not-taken with a foreign tag keeps the entry, matching tag clears it
        step(8'h81, 1'b1, 8'h81, 8'h00, 1'b0, 8'h82, "R9");
        step(8'h61, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00, "R7");
        step(8'h61, 1'b1, 8'h61, 8'h00, 1'b0, 8'h07, "R9");
        step(8'h61, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00, "R7");
        // R11: update fields active but valid low
        step(8'h10, 1'b0, 8'h10, 8'h02, 1'b1, 8'h00, "R11");
        step(8'h10, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00, "R11");

        // Near-exhaustive: patterned updates, full lookup sweep after each
        for (int k = 0; k < 260; k++) begin
            logic [PW-1:0] pc, tg, pn;
            logic tk;
            pc = PW'(k * 37 + 5);
            tg = PW'(k * 91 + 3);
            tk = (k % 3) != 0;
            pn = m_next(2, pc);
            if (k % 2 == 1) pn = pn ^ 8'h5a;
            step(pc, 1'b1, pc, tg, tk, pn, "R9");
            sweep("");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
            $finish;
        end
    end

endmodule